// File: doc/BRIEF.md
# Prioritized Interrupt Level Arbiter

This block merges every interrupt source of one processor core into a single prioritized request. The sources are fifteen external level lines (levels 1 to 15), a 17-bit software-interrupt register and the two timer-match flags held inside that register. The timer-match flags both fold into level 14. Each cycle the block builds the pending-level vector and drops the request when nothing is pending. Otherwise, while interrupts are globally enabled, it scans from level 15 downward for the first pending level strictly above the core's mask level. It encodes the winner as a trap index. It raises the request unless a trap of higher type is already in service at a nonzero trap level.

The request and index are state. They change only when the encoded index differs from the stored one, or when the pending vector becomes empty. A separate wake pulse reports any rising external line, whether or not it leads to a request. All outputs are registered and react one clock after an input change. The core's trap logic samples `irq_req_o` and `irq_idx_o`. Its halt logic uses `wake_o`.

Top module: `irq_level_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after release with all inputs zero, the request is 0, the index is 0 and the wake output is 0.
- R2: The pending vector is the OR of the external lines and the software register. External port bit n is level n, and software bit n (1 to 15) is level n.
- R3: Software bit 0 (tick match) and software bit 16 (system-tick match) each make level 14 pending. Neither is a level of its own.
- R4: With interrupts enabled, the highest pending level L that is strictly greater than the mask level wins. One clock later the request is 1 and the index is 0x40 | L, so levels 1..15 map to 0x41..0x4F.
- R5: If levels are pending but none is above the mask level, the request and index keep their values.
- R6: When no level is pending and the request is 1, the request falls to 0 and the index to 0 on the next clock. This happens even with interrupts disabled. A request of 0 always comes with an index of 0.
- R7: With interrupts disabled and some level pending, the request and index keep their values.
- R8: If the trap level is nonzero and the in-service trap type is strictly greater than the new index, nothing changes. An equal type, or a trap level of zero, lets the update through.
- R9: The request and index are written only when the new index differs from the stored one. A higher or a lower winner both replace the stored index.
- R10: The wake output is 1 for the cycle after any external line goes from 0 to 1, even if no request results. Falling lines and software bits never wake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lvl_i | input | 15 | External level lines, bit n is level n (bits 15:1) |
| softint_i | input | 17 | Software-interrupt register; bit 0 tick match, bit 16 system-tick match |
| int_en_i | input | 1 | Global interrupt enable of the core |
| pil_i | input | 4 | Current interrupt mask level |
| tl_i | input | 3 | Current trap level |
| tt_cur_i | input | 9 | Trap type currently in service |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_idx_o | output | 7 | Encoded trap index, 0x40 | level |
| wake_o | output | 1 | One-cycle pulse on a rising external line |

## Verification
The bound checker watches several rules on every cycle. It checks that an empty pending vector drops the request and clears the index, and that an idle request always carries index 0. It checks that an asserted index has the 0x4_ form with a nonzero level. Any index change must lie above the previous mask level and must not undercut an in-service trap at nonzero trap level. A disabled core with pending levels must hold its outputs, and a wake must follow a nonzero line. The checker cannot show which level wins the scan, how the timer flags fold into level 14, how an equal trap type passes, or that a repeated winner leaves the state alone. The bench's scoreboard steps through those cases with expected values computed by hand.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned LEVELS_DEF    = 16;
  localparam int unsigned SOFT_W_DEF    = 17;
  localparam int unsigned IDX_W_DEF     = 7;
  localparam int unsigned TL_W_DEF      = 3;
  localparam int unsigned TT_W_DEF      = 9;
  localparam int unsigned TRAP_BASE_DEF = 'h40;
  localparam int unsigned TICK_BIT_DEF  = 0;
  localparam int unsigned STICK_BIT_DEF = 16;
  localparam int unsigned TIMER_LVL_DEF = 14;
endpackage

// File: rtl/irq_pend_merge.sv
module irq_pend_merge #(
  parameter int unsigned LEVELS    = 16,
  parameter int unsigned SOFT_W    = 17,
  parameter int unsigned TICK_BIT  = 0,
  parameter int unsigned STICK_BIT = 16,
  parameter int unsigned TIMER_LVL = 14
) (
  input  logic [LEVELS-1:1] ext_i,
  input  logic [SOFT_W-1:0] soft_i,
  output logic [LEVELS-1:1] pend_o
);
  logic timer_hit;
  assign timer_hit = soft_i[TICK_BIT] | soft_i[STICK_BIT];

  for (genvar l = 1; l < LEVELS; l++) begin : g_lvl
    logic soft_bit;
    if (l == TICK_BIT || l == STICK_BIT || l >= SOFT_W) begin : g_nosoft
      assign soft_bit = 1'b0;
    end else begin : g_soft
      assign soft_bit = soft_i[l];
    end
    if (l == TIMER_LVL) begin : g_timer
      assign pend_o[l] = ext_i[l] | soft_bit | timer_hit;
    end else begin : g_plain
      assign pend_o[l] = ext_i[l] | soft_bit;
    end
  end
endmodule

// File: rtl/irq_level_scan.sv
module irq_level_scan #(
  parameter int unsigned LEVELS = 16,
  localparam int unsigned LVL_W = $clog2(LEVELS)
) (
  input  logic [LEVELS-1:1] pend_i,
  input  logic [LVL_W-1:0]  mask_i,
  output logic              found_o,
  output logic [LVL_W-1:0]  lvl_o
);
  logic [LEVELS-1:1] qual;

  for (genvar l = 1; l < LEVELS; l++) begin : g_q
    assign qual[l] = pend_i[l] && (l > int'(mask_i));
  end

  // ascending walk: the last hit is the highest qualifying level
  always_comb begin
    found_o = 1'b0;
    lvl_o   = '0;
    for (int l = 1; l < LEVELS; l++) begin
      if (qual[l]) begin
        found_o = 1'b1;
        lvl_o   = LVL_W'(l);
      end
    end
  end
endmodule

// File: rtl/irq_rise_detect.sv
module irq_rise_detect #(
  parameter int unsigned W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lines_i,
  output logic         rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      rise_o <= 1'b0;
    end else begin
      prev_q <= lines_i;
      rise_o <= |(lines_i & ~prev_q);
    end
  end
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned LEVELS    = LEVELS_DEF,
  parameter int unsigned SOFT_W    = SOFT_W_DEF,
  parameter int unsigned IDX_W     = IDX_W_DEF,
  parameter int unsigned TL_W      = TL_W_DEF,
  parameter int unsigned TT_W      = TT_W_DEF,
  parameter int unsigned TRAP_BASE = TRAP_BASE_DEF,
  parameter int unsigned TICK_BIT  = TICK_BIT_DEF,
  parameter int unsigned STICK_BIT = STICK_BIT_DEF,
  parameter int unsigned TIMER_LVL = TIMER_LVL_DEF,
  localparam int unsigned LVL_W    = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:1] irq_lvl_i,
  input  logic [SOFT_W-1:0] softint_i,
  input  logic              int_en_i,
  input  logic [LVL_W-1:0]  pil_i,
  input  logic [TL_W-1:0]   tl_i,
  input  logic [TT_W-1:0]   tt_cur_i,
  output logic              irq_req_o,
  output logic [IDX_W-1:0]  irq_idx_o,
  output logic              wake_o
);
  logic [LEVELS-1:1] pend;
  logic              win_found;
  logic [LVL_W-1:0]  win_lvl;
  logic [IDX_W-1:0]  new_idx;
  logic              nested_block;
  logic              take;

  irq_pend_merge #(
    .LEVELS(LEVELS), .SOFT_W(SOFT_W), .TICK_BIT(TICK_BIT),
    .STICK_BIT(STICK_BIT), .TIMER_LVL(TIMER_LVL)
  ) u_merge (
    .ext_i (irq_lvl_i),
    .soft_i(softint_i),
    .pend_o(pend)
  );

  irq_level_scan #(.LEVELS(LEVELS)) u_scan (
    .pend_i (pend),
    .mask_i (pil_i),
    .found_o(win_found),
    .lvl_o  (win_lvl)
  );

  irq_rise_detect #(.W(LEVELS-1)) u_wake (
    .clk    (clk),
    .rst_n  (rst_n),
    .lines_i(irq_lvl_i),
    .rise_o (wake_o)
  );

  assign new_idx      = IDX_W'(TRAP_BASE) | IDX_W'(win_lvl);
  assign nested_block = (tl_i != '0) &&
                        (tt_cur_i > {{(TT_W-IDX_W){1'b0}}, new_idx});
  assign take         = int_en_i && win_found && !nested_block &&
                        (new_idx != irq_idx_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req_o <= 1'b0;
      irq_idx_o <= '0;
    end else if (pend == '0) begin
      if (irq_req_o) begin
        irq_req_o <= 1'b0;
        irq_idx_o <= '0;
      end
    end else if (take) begin
      irq_req_o <= 1'b1;
      irq_idx_o <= new_idx;
    end
  end
endmodule

// File: rtl/irq_level_arbiter_chk.sv
module irq_level_arbiter_chk #(
  parameter int unsigned LEVELS    = 16,
  parameter int unsigned SOFT_W    = 17,
  parameter int unsigned IDX_W     = 7,
  parameter int unsigned TL_W      = 3,
  parameter int unsigned TT_W      = 9,
  parameter int unsigned TRAP_BASE = 'h40,
  localparam int unsigned LVL_W    = $clog2(LEVELS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LEVELS-1:1] irq_lvl_i,
  input logic [SOFT_W-1:0] softint_i,
  input logic              int_en_i,
  input logic [LVL_W-1:0]  pil_i,
  input logic [TL_W-1:0]   tl_i,
  input logic [TT_W-1:0]   tt_cur_i,
  input logic              irq_req_o,
  input logic [IDX_W-1:0]  irq_idx_o,
  input logic              wake_o
);
  localparam logic [IDX_W-1:0] HI_MASK = ~IDX_W'((1 << LVL_W) - 1);

  a_r6_drop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lvl_i == '0 && softint_i == '0 && irq_req_o)
      |=> (!irq_req_o && irq_idx_o == '0));

  a_r6_idle_zero_idx: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req_o |-> (irq_idx_o == '0));

  a_r4_index_form: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> ((irq_idx_o & HI_MASK) == IDX_W'(TRAP_BASE) &&
                   irq_idx_o[LVL_W-1:0] != '0));

  a_r4_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_o && !$stable(irq_idx_o))
      |-> (irq_idx_o[LVL_W-1:0] > $past(pil_i)));

  a_r7_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_en_i && (irq_lvl_i != '0 || softint_i != '0))
      |=> ($stable(irq_req_o) && $stable(irq_idx_o)));

  a_r8_nested_block: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_o && !$stable(irq_idx_o))
      |-> !($past(tl_i) != '0 &&
            $past(tt_cur_i) > {{(TT_W-IDX_W){1'b0}}, irq_idx_o}));

  a_r10_wake_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> ($past(irq_lvl_i) != '0));
endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(
  .LEVELS(LEVELS), .SOFT_W(SOFT_W), .IDX_W(IDX_W),
  .TL_W(TL_W), .TT_W(TT_W), .TRAP_BASE(TRAP_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_lvl_i(irq_lvl_i), .softint_i(softint_i),
  .int_en_i(int_en_i), .pil_i(pil_i), .tl_i(tl_i), .tt_cur_i(tt_cur_i),
  .irq_req_o(irq_req_o), .irq_idx_o(irq_idx_o), .wake_o(wake_o)
);

// File: tb/tb_irq_level_arbiter.sv
module tb_irq_level_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:1] irq_lvl = '0;
  logic [16:0] softint = '0;
  logic        int_en = 1'b1;
  logic [3:0]  pil = '0;
  logic [2:0]  tl = '0;
  logic [8:0]  tt_cur = '0;
  logic        irq_req;
  logic [6:0]  irq_idx;
  logic        wake;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [15:1] prev_ext = '0;

  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  irq_level_arbiter dut (
    .clk(clk), .rst_n(rst_n), .irq_lvl_i(irq_lvl), .softint_i(softint),
    .int_en_i(int_en), .pil_i(pil), .tl_i(tl), .tt_cur_i(tt_cur),
    .irq_req_o(irq_req), .irq_idx_o(irq_idx), .wake_o(wake)
  );

  function automatic logic [15:1] lv(input int n);
    logic [15:1] v = '0;
    v[n] = 1'b1;
    return v;
  endfunction

  task automatic check(input logic [8:0] got, input logic [8:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got wake=%0b req=%0b idx=%h, expected wake=%0b req=%0b idx=%h",
               tag, got[8], got[7], got[6:0], exp[8], exp[7], exp[6:0]);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the expected outputs
  task automatic step(input logic [15:1] e, input logic [16:0] s, input logic en,
                      input logic [3:0] p, input logic [2:0] t, input logic [8:0] tt,
                      input logic er, input logic [6:0] ei, input string tag);
    logic ew;
    @(negedge clk);
    irq_lvl = e; softint = s; int_en = en; pil = p; tl = t; tt_cur = tt;
    ew = |(e & ~prev_ext);
    prev_ext = e;
    exp_q.push_back({ew, er, ei});
    tag_q.push_back(tag);
  endtask

  // monitor: compare after each edge that consumed a queued step
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [8:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({wake, irq_req, irq_idx}, e, t);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({wake, irq_req, irq_idx}, 9'h000, "R1 during reset");
    rst_n = 1'b1;
    step('0, '0, 1, 0, 0, 0, 0, 7'h00, "R1 after reset");
    step(lv(5), '0, 1, 0, 0, 0, 1, 7'h45, "R4 level 5 wins, R10 wake");
    step(lv(5), '0, 1, 0, 0, 0, 1, 7'h45, "R9 same winner holds");
    step(lv(5)|lv(9), '0, 1, 0, 0, 0, 1, 7'h49, "R9 higher level replaces");
    step(lv(5), '0, 1, 0, 0, 0, 1, 7'h45, "R9 lower level replaces, R10 no wake on fall");
    step('0, 17'(1 << 3), 1, 0, 0, 0, 1, 7'h43, "R2 software bit 3 is level 3");
    step('0, 17'(1 << 0), 1, 0, 0, 0, 1, 7'h4E, "R3 tick match gives level 14");
    step('0, 17'(1 << 16), 1, 0, 0, 0, 1, 7'h4E, "R3 system-tick match gives level 14");
    step('0, '0, 1, 0, 0, 0, 0, 7'h00, "R6 empty vector drops request");
    step('0, 17'(1 << 15), 1, 0, 0, 0, 1, 7'h4F, "R2 software bit 15");
    step('0, 17'(1 << 15), 1, 15, 0, 0, 1, 7'h4F, "R5 nothing above mask keeps state");
    step('0, '0, 1, 15, 0, 0, 0, 7'h00, "R6 drop with high mask");
    step(lv(3)|lv(7), '0, 1, 7, 0, 0, 0, 7'h00, "R5 levels at or below mask, R10 wake without request");
    step(lv(3)|lv(7)|lv(8), '0, 1, 7, 0, 0, 1, 7'h48, "R4 strictly above mask");
    step(lv(3)|lv(7)|lv(8)|lv(12), '0, 0, 0, 0, 0, 1, 7'h48, "R7 disabled holds");
    step('0, '0, 0, 0, 0, 0, 0, 7'h00, "R6 drop while disabled");
    step(lv(10), '0, 0, 0, 0, 0, 0, 7'h00, "R7 disabled no raise");
    step(lv(10), '0, 1, 0, 0, 0, 1, 7'h4A, "R7 enable resumes");
    step(lv(10)|lv(11), '0, 1, 0, 1, 9'h04C, 1, 7'h4A, "R8 higher in-service type blocks");
    step(lv(10)|lv(11), '0, 1, 0, 1, 9'h04B, 1, 7'h4B, "R8 equal in-service type passes");
    step(lv(10)|lv(11)|lv(13), '0, 1, 0, 0, 9'h07F, 1, 7'h4D, "R8 trap level zero ignores type");
    step(lv(13), 17'(1 << 0), 1, 13, 0, 0, 1, 7'h4E, "R3 timer level above mask 13");
    step('0, 17'(1 << 0), 1, 14, 0, 0, 1, 7'h4E, "R5 timer level equal to mask holds");
    step('0, '0, 1, 0, 0, 0, 0, 7'h00, "R6 final drop");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard: %0d expected items left, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule